// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Unit

This block sits beside a dual-clock FIFO and produces its two programmable threshold flags. It holds an almost-empty offset and an almost-full offset. It compares them with the fill level seen in each clock domain, and drives two active-low outputs: `almost_empty_n` and `almost_full_n`. The pointers arrive already synchronised into each domain. The FIFO storage and the pointer logic belong to the surrounding design.

The offsets take one of eight defaults at master reset. The select pins and the load pin choose the default. Software can then rewrite the offsets in two ways: from the write data bus, or bit by bit over a slow serial input. It can also read them back over the read data bus.

A mode pin, sampled at master reset, chooses the flag timing:
- In synchronous mode each flag is recomputed only in its own domain.
- In asynchronous mode a flag is set by a pointer move in its own domain, and cleared by a condition that starts in the opposite domain and passes through a synchroniser.

A partial reset restarts the flags and the load/readback sequencing. It keeps the offsets and the mode.

Top module: `pflag_unit`

## Requirements
- R1: During master reset the code {cfg_sel[1], cfg_sel[0], ofs_ld} (cfg_sel[1] is the most significant bit) selects index n in 0..7. Both offsets become 2^(n+3)-1, giving 7, 15, 31, 63, 127, 255, 511 or 1023.
- R2: Fill level is count = wptr - rptr modulo 2^(AW+1). In synchronous mode, `almost_empty_n` is low exactly when the read-domain count is at most the empty offset. It reflects the read-domain pointers one read-clock cycle after they change.
- R3: In synchronous mode, `almost_full_n` is low exactly when the write-domain free space (2^AW minus count) is at most the full offset. It reflects the write-domain pointers one write-clock cycle after they change.
- R4: A write-clock edge with `wr_en` and `ofs_ld` both high loads `wr_data` into one offset. Successive loads alternate, starting with the empty offset. The new value governs the flags from the next cycle.
- R5: When `ser_en` and `ofs_ld` are high, each rising edge of `ser_clk` shifts `ser_in` into a 2*AW-bit chain {full offset, empty offset}. The chain enters at the MSB of the full offset and moves toward the LSB of the empty offset, so the first of 2*AW bits ends at empty bit 0. Each `ser_clk` level must be held for at least three write-clock cycles. A bit takes effect three write-clock edges after its rising edge.
- R6: A read-clock edge with `rd_en` and `ofs_ld` both high places an offset on `rd_data` one cycle later. Successive readbacks alternate, starting with the empty offset. At any other time `rd_data` holds its value.
- R7: `flag_mode_sync` is sampled only during master reset: 1 selects synchronous timing and 0 selects asynchronous timing. Changing it afterwards has no effect.
- R8: In asynchronous mode, either of these sets a flag one own-domain cycle later: a move of the own-domain pointer that changes the read pointer for almost-empty, or that changes the write pointer for almost-full, while the own-domain condition holds. A rise of the opposite-domain "beyond threshold" condition clears the flag four own-domain cycles after the opposite-domain pointer change, whatever the own-domain pointers say.
- R9: Partial reset keeps both offsets and the mode. It returns the load and readback alternation to the empty offset, asserts almost-empty and releases almost-full.
- R10: After master reset `almost_empty_n` is 0, `almost_full_n` is 1 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| ser_clk | input | 1 | Serial offset clock, oversampled by wr_clk |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| cfg_sel | input | 2 | Default offset select, sampled at master reset |
| ofs_ld | input | 1 | Offset load/readback qualifier; also default select bit 0 |
| flag_mode_sync | input | 1 | Flag timing select, sampled at master reset |
| wr_en | input | 1 | Write enable (parallel offset load with ofs_ld) |
| wr_data | input | AW | Write data bus |
| rd_en | input | 1 | Read enable (offset readback with ofs_ld) |
| rd_data | output | AW | Readback data bus |
| ser_en | input | 1 | Serial load enable |
| ser_in | input | 1 | Serial data in |
| wptr_wr | input | AW+1 | Write pointer, write domain |
| rptr_wr | input | AW+1 | Read pointer synchronised into write domain |
| wptr_rd | input | AW+1 | Write pointer synchronised into read domain |
| rptr_rd | input | AW+1 | Read pointer, read domain |
| almost_empty_n | output | 1 | Almost-empty flag, active low |
| almost_full_n | output | 1 | Almost-full flag, active low |

## Verification
The results are due at fixed distances from the stimulus:
- Synchronous flags and readback data appear one clock edge after the input changes.
- An asynchronous set appears after one edge, and an asynchronous release after four.
- A serial bit lands three edges after its `ser_clk` rise.

The driver tasks turn each of these into an expected value stamped with its due cycle, counted from the edge after the stimulus. The monitor compares only when that due cycle arrives, away from the clock edge. For the asynchronous release the driver also schedules a check one cycle early, which still expects the old level. The next stimulus waits until the queue has drained.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

    typedef enum logic {
        FLAG_ASYNC = 1'b0,
        FLAG_SYNC  = 1'b1
    } flag_mode_e;

    // Default offset for a 3-bit code n: 2^(n+3) - 1
    function automatic int dflt_offset(input logic [2:0] code);
        return (1 << (int'(code) + 3)) - 1;
    endfunction

endpackage

// File: rtl/pflag_ser_rx.sv
// Oversamples the serial offset interface in the write-clock domain.
module pflag_ser_rx (
    input  logic clk,
    input  logic rst,
    input  logic ser_clk,
    input  logic ser_en,
    input  logic ser_in,
    output logic bit_stb,
    output logic bit_val
);
    typedef struct packed {
        logic [2:0] ck;
        logic [1:0] en;
        logic [1:0] dat;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d     = rx_q;
        rx_d.ck  = {rx_q.ck[1:0], ser_clk};
        rx_d.en  = {rx_q.en[0], ser_en};
        rx_d.dat = {rx_q.dat[0], ser_in};
        if (rst) rx_d = '0;
    end

    always_ff @(posedge clk) rx_q <= rx_d;

    assign bit_stb = rx_q.ck[1] & ~rx_q.ck[2] & rx_q.en[1];
    assign bit_val = rx_q.dat[1];
endmodule

// File: rtl/pflag_ofs_regs.sv
// Offset registers and timing mode, write-clock domain.
module pflag_ofs_regs
    import pflag_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             prst,
    input  logic [1:0]       cfg_sel,
    input  logic             ofs_ld,
    input  logic             mode_pin,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic             ser_stb,
    input  logic             ser_val,
    output logic [OFS_W-1:0] ofs_e,
    output logic [OFS_W-1:0] ofs_f,
    output logic             mode_sync
);
    typedef struct packed {
        logic [OFS_W-1:0] f;
        logic [OFS_W-1:0] e;
        logic             sel_full;
        flag_mode_e       mode;
    } ofs_t;

    ofs_t ofs_d, ofs_q;

    always_comb begin
        ofs_d = ofs_q;
        if (mrst) begin
            ofs_d.e        = OFS_W'(dflt_offset({cfg_sel, ofs_ld}));
            ofs_d.f        = OFS_W'(dflt_offset({cfg_sel, ofs_ld}));
            ofs_d.mode     = mode_pin ? FLAG_SYNC : FLAG_ASYNC;
            ofs_d.sel_full = 1'b0;
        end else if (prst) begin
            ofs_d.sel_full = 1'b0;
        end else if (wr_en && ofs_ld) begin
            if (ofs_q.sel_full) ofs_d.f = wr_ofs;
            else                ofs_d.e = wr_ofs;
            ofs_d.sel_full = ~ofs_q.sel_full;
        end else if (ser_stb && ofs_ld) begin
            {ofs_d.f, ofs_d.e} = {ser_val, ofs_q.f, ofs_q.e[OFS_W-1:1]};
        end
    end

    always_ff @(posedge clk) ofs_q <= ofs_d;

    assign ofs_e     = ofs_q.e;
    assign ofs_f     = ofs_q.f;
    assign mode_sync = (ofs_q.mode == FLAG_SYNC);
endmodule

// File: rtl/pflag_rdback.sv
// Offset readback, read-clock domain.
module pflag_rdback #(
    parameter int OFS_W = 11
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             prst,
    input  logic             rd_en,
    input  logic             ofs_ld,
    input  logic [OFS_W-1:0] ofs_e,
    input  logic [OFS_W-1:0] ofs_f,
    output logic [OFS_W-1:0] rd_data
);
    typedef struct packed {
        logic [OFS_W-1:0] data;
        logic             sel_full;
    } rb_t;

    rb_t rb_d, rb_q;

    always_comb begin
        rb_d = rb_q;
        if (mrst) begin
            rb_d = '0;
        end else if (prst) begin
            rb_d.sel_full = 1'b0;
        end else if (rd_en && ofs_ld) begin
            rb_d.data     = rb_q.sel_full ? ofs_f : ofs_e;
            rb_d.sel_full = ~rb_q.sel_full;
        end
    end

    always_ff @(posedge clk) rb_q <= rb_d;

    assign rd_data = rb_q.data;
endmodule

// File: rtl/pflag_flag.sv
// One threshold flag. Synchronous mode: own-domain compare.
// Asynchronous mode: set by an own-domain pointer move, cleared by a
// synchronised rise of the opposite-domain "beyond threshold" level.
module pflag_flag #(
    parameter int   PTR_W       = 12,
    parameter int   SYNC_STAGES = 2,
    parameter logic RST_ACT     = 1'b1
) (
    input  logic             own_clk,
    input  logic             oth_clk,
    input  logic             mrst,
    input  logic             prst,
    input  logic             mode_sync,
    input  logic [PTR_W-1:0] own_ptr,
    input  logic             own_near,
    input  logic             oth_far,
    output logic             flag_act
);
    logic lvl_d, lvl_q;

    always_comb lvl_d = (mrst || prst) ? 1'b0 : oth_far;
    always_ff @(posedge oth_clk) lvl_q <= lvl_d;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sh;
        logic                   prev_lvl;
        logic [PTR_W-1:0]       prev_ptr;
        logic                   flag;
    } own_t;

    own_t own_d, own_q;
    logic clr_evt;
    logic set_evt;

    assign clr_evt = own_q.sh[SYNC_STAGES-1] & ~own_q.prev_lvl;
    assign set_evt = (own_ptr != own_q.prev_ptr) & own_near;

    always_comb begin
        own_d          = own_q;
        own_d.sh       = {own_q.sh[SYNC_STAGES-2:0], lvl_q};
        own_d.prev_lvl = own_q.sh[SYNC_STAGES-1];
        own_d.prev_ptr = own_ptr;
        if (mrst || prst) begin
            own_d.flag     = RST_ACT;
            own_d.sh       = '0;
            own_d.prev_lvl = 1'b0;
        end else if (mode_sync) begin
            own_d.flag = own_near;
        end else if (set_evt) begin
            own_d.flag = 1'b1;
        end else if (clr_evt) begin
            own_d.flag = 1'b0;
        end
    end

    always_ff @(posedge own_clk) own_q <= own_d;

    assign flag_act = own_q.flag;
endmodule

// File: rtl/pflag_unit.sv
module pflag_unit #(
    parameter int AW = 11
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          ser_clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic [1:0]    cfg_sel,
    input  logic          ofs_ld,
    input  logic          flag_mode_sync,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    input  logic          rd_en,
    output logic [AW-1:0] rd_data,
    input  logic          ser_en,
    input  logic          ser_in,
    input  logic [AW:0]   wptr_wr,
    input  logic [AW:0]   rptr_wr,
    input  logic [AW:0]   wptr_rd,
    input  logic [AW:0]   rptr_rd,
    output logic          almost_empty_n,
    output logic          almost_full_n
);
    localparam int          PTR_W = AW + 1;
    localparam logic [AW:0] DEPTH = {1'b1, {AW{1'b0}}};

    logic [AW-1:0]    ofs_e, ofs_f;
    logic             mode_sync;
    logic             ser_stb, ser_val;
    logic [PTR_W-1:0] wcnt, rcnt, wfree, rfree, ofs_e_x, ofs_f_x;
    logic             ae_act, af_act;

    pflag_ser_rx u_ser (
        .clk     (wr_clk),
        .rst     (mrst || prst),
        .ser_clk (ser_clk),
        .ser_en  (ser_en),
        .ser_in  (ser_in),
        .bit_stb (ser_stb),
        .bit_val (ser_val)
    );

    pflag_ofs_regs #(.OFS_W(AW)) u_ofs (
        .clk       (wr_clk),
        .mrst      (mrst),
        .prst      (prst),
        .cfg_sel   (cfg_sel),
        .ofs_ld    (ofs_ld),
        .mode_pin  (flag_mode_sync),
        .wr_en     (wr_en),
        .wr_ofs    (wr_data),
        .ser_stb   (ser_stb),
        .ser_val   (ser_val),
        .ofs_e     (ofs_e),
        .ofs_f     (ofs_f),
        .mode_sync (mode_sync)
    );

    pflag_rdback #(.OFS_W(AW)) u_rb (
        .clk     (rd_clk),
        .mrst    (mrst),
        .prst    (prst),
        .rd_en   (rd_en),
        .ofs_ld  (ofs_ld),
        .ofs_e   (ofs_e),
        .ofs_f   (ofs_f),
        .rd_data (rd_data)
    );

    assign wcnt    = wptr_wr - rptr_wr;
    assign rcnt    = wptr_rd - rptr_rd;
    assign wfree   = DEPTH - wcnt;
    assign rfree   = DEPTH - rcnt;
    assign ofs_e_x = {1'b0, ofs_e};
    assign ofs_f_x = {1'b0, ofs_f};

    // Almost-empty lives in the read domain, released from the write side
    pflag_flag #(.PTR_W(PTR_W), .SYNC_STAGES(2), .RST_ACT(1'b1)) u_ae (
        .own_clk   (rd_clk),
        .oth_clk   (wr_clk),
        .mrst      (mrst),
        .prst      (prst),
        .mode_sync (mode_sync),
        .own_ptr   (rptr_rd),
        .own_near  (rcnt <= ofs_e_x),
        .oth_far   (wcnt > ofs_e_x),
        .flag_act  (ae_act)
    );

    // Almost-full lives in the write domain, released from the read side
    pflag_flag #(.PTR_W(PTR_W), .SYNC_STAGES(2), .RST_ACT(1'b0)) u_af (
        .own_clk   (wr_clk),
        .oth_clk   (rd_clk),
        .mrst      (mrst),
        .prst      (prst),
        .mode_sync (mode_sync),
        .own_ptr   (wptr_wr),
        .own_near  (wfree <= ofs_f_x),
        .oth_far   (rfree > ofs_f_x),
        .flag_act  (af_act)
    );

    assign almost_empty_n = ~ae_act;
    assign almost_full_n  = ~af_act;
endmodule

// File: rtl/pflag_chk.sv
module pflag_chk #(
    parameter int AW = 11
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          mrst,
    input logic          prst,
    input logic          rd_en,
    input logic          ofs_ld,
    input logic [AW-1:0] rd_data,
    input logic [AW:0]   rptr_rd,
    input logic          almost_empty_n,
    input logic          almost_full_n,
    input logic          mode_sync,
    input logic [AW-1:0] ofs_e,
    input logic [AW-1:0] ofs_f
);
    AST_MRST_AE: assert property (@(posedge rd_clk) mrst |=> !almost_empty_n) else $error("AST_MRST_AE"); // R10
    AST_MRST_AF: assert property (@(posedge wr_clk) mrst |=> almost_full_n) else $error("AST_MRST_AF"); // R10
    AST_RD_HOLD: assert property (@(posedge rd_clk) disable iff (mrst) !(rd_en && ofs_ld) |=> $stable(rd_data)) else $error("AST_RD_HOLD"); // R6
    AST_PRST_KEEP: assert property (@(posedge wr_clk) disable iff (mrst) prst |=> ($stable(ofs_e) && $stable(ofs_f) && $stable(mode_sync))) else $error("AST_PRST_KEEP"); // R9
    AST_ASYNC_AE_SET: assert property (@(posedge rd_clk) disable iff (mrst || prst) (!mode_sync && $fell(almost_empty_n)) |-> ($past(rptr_rd) != $past(rptr_rd, 2))) else $error("AST_ASYNC_AE_SET"); // R8
endmodule

bind pflag_unit pflag_chk #(.AW(AW)) u_chk (
    .wr_clk         (wr_clk),
    .rd_clk         (rd_clk),
    .mrst           (mrst),
    .prst           (prst),
    .rd_en          (rd_en),
    .ofs_ld         (ofs_ld),
    .rd_data        (rd_data),
    .rptr_rd        (rptr_rd),
    .almost_empty_n (almost_empty_n),
    .almost_full_n  (almost_full_n),
    .mode_sync      (mode_sync),
    .ofs_e          (ofs_e),
    .ofs_f          (ofs_f)
);

// File: tb/tb_pflag_unit.sv
`timescale 1ns/1ps
module tb_pflag_unit;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          ser_clk = 1'b0;
    logic          mrst = 1'b1, prst = 1'b0;
    logic [1:0]    cfg_sel = 2'b00;
    logic          ofs_ld = 1'b0, flag_mode_sync = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0, ser_en = 1'b0, ser_in = 1'b0;
    logic [AW-1:0] wr_data = '0;
    logic [AW-1:0] rd_data;
    logic [AW:0]   wptr_wr = '0, rptr_wr = '0, wptr_rd = '0, rptr_rd = '0;
    logic          almost_empty_n, almost_full_n;

    always #5 clk = ~clk;

    pflag_unit #(.AW(AW)) dut (
        .wr_clk(clk), .rd_clk(clk), .ser_clk(ser_clk),
        .mrst(mrst), .prst(prst), .cfg_sel(cfg_sel), .ofs_ld(ofs_ld),
        .flag_mode_sync(flag_mode_sync), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .ser_en(ser_en), .ser_in(ser_in),
        .wptr_wr(wptr_wr), .rptr_wr(rptr_wr), .wptr_rd(wptr_rd), .rptr_rd(rptr_rd),
        .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
    );

    typedef enum int {SIG_AE = 0, SIG_AF = 1, SIG_RD = 2} sig_e;
    typedef struct {
        int    due;
        sig_e  sig;
        int    exp;
        string tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item whose due cycle has arrived
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                int act;
                case (q[i].sig)
                    SIG_AE:  act = int'(almost_empty_n);
                    SIG_AF:  act = int'(almost_full_n);
                    default: act = int'(rd_data);
                endcase
                checks++;
                if (act != q[i].exp) begin
                    errors++;
                    $display("FAIL %s sig=%0d actual=%0d expected=%0d", q[i].tag, q[i].sig, act, q[i].exp);
                end
                q.delete(i);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic expect_at(input sig_e s, input int exp, input int dly, input string tag);
        item_t it;
        it.due = cyc + dly;
        it.sig = s;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_ptrs(input int ww, input int rw, input int wr, input int rr);
        wptr_wr = (AW+1)'(ww);
        rptr_wr = (AW+1)'(rw);
        wptr_rd = (AW+1)'(wr);
        rptr_rd = (AW+1)'(rr);
    endtask

    task automatic do_mrst(input logic sync, input logic [1:0] sel, input logic ld);
        @(negedge clk);
        flag_mode_sync = sync;
        cfg_sel = sel;
        ofs_ld = ld;
        set_ptrs(0, 0, 0, 0);
        mrst = 1'b1;
        repeat (3) @(negedge clk);
        mrst = 1'b0;
        ofs_ld = 1'b0;
    endtask

    task automatic read_two(input int exp_e, input int exp_f, input string tag);
        @(negedge clk);
        ofs_ld = 1'b1;
        rd_en = 1'b1;
        expect_at(SIG_RD, exp_e, 1, tag);
        expect_at(SIG_RD, exp_f, 2, tag);
        @(negedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        ofs_ld = 1'b0;
        drain();
    endtask

    task automatic read_one(input int exp, input string tag);
        @(negedge clk);
        ofs_ld = 1'b1;
        rd_en = 1'b1;
        expect_at(SIG_RD, exp, 1, tag);
        @(negedge clk);
        rd_en = 1'b0;
        ofs_ld = 1'b0;
        drain();
    endtask

    task automatic ptr_check(input int ww, input int rw, input int wr, input int rr,
                             input sig_e s, input int exp, input int dly, input string tag);
        @(negedge clk);
        set_ptrs(ww, rw, wr, rr);
        expect_at(s, exp, dly, tag);
        drain();
    endtask

    task automatic par_load(input int e, input int f);
        @(negedge clk);
        ofs_ld = 1'b1;
        wr_en = 1'b1;
        wr_data = AW'(e);
        @(negedge clk);
        wr_data = AW'(f);
        @(negedge clk);
        wr_en = 1'b0;
        ofs_ld = 1'b0;
    endtask

    task automatic ser_load(input int e, input int f);
        logic [2*AW-1:0] chain;
        chain = {AW'(f), AW'(e)};
        @(negedge clk);
        ofs_ld = 1'b1;
        ser_en = 1'b1;
        for (int b = 0; b < 2*AW; b++) begin
            ser_in = chain[b];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (4) @(negedge clk);
        ser_en = 1'b0;
        ofs_ld = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        // R10 / R1: master reset, sync mode, code {1,0,1} = 5 -> 255
        do_mrst(1'b1, 2'b10, 1'b1);
        expect_at(SIG_AE, 0, 0, "R10 reset ae_n");
        expect_at(SIG_AF, 1, 0, "R10 reset af_n");
        expect_at(SIG_RD, 0, 0, "R10 reset rd_data");
        @(negedge clk);
        drain();
        read_two(255, 255, "R1 default code5");

        // R2 / R3: synchronous thresholds at offset 255
        ptr_check(256, 0, 256, 0, SIG_AE, 1, 1, "R2 count 256 above empty offset");
        ptr_check(255, 0, 255, 0, SIG_AE, 0, 1, "R2 count 255 at empty offset");
        ptr_check(1792, 0, 1792, 0, SIG_AF, 1, 1, "R3 free 256 above full offset");
        ptr_check(1793, 0, 1793, 0, SIG_AF, 0, 1, "R3 free 255 at full offset");
        ptr_check(0, 0, 0, 0, SIG_AF, 1, 1, "R3 empty releases full");

        // R4: parallel load alternates empty then full
        par_load(100, 50);
        read_two(100, 50, "R4 parallel load order");
        ptr_check(100, 0, 100, 0, SIG_AE, 0, 1, "R4 new empty offset 100 inclusive");
        ptr_check(101, 0, 101, 0, SIG_AE, 1, 1, "R4 new empty offset 100 exceeded");
        ptr_check(1998, 0, 1998, 0, SIG_AF, 0, 1, "R4 new full offset 50");
        ptr_check(0, 0, 0, 0, SIG_AE, 0, 1, "R2 back to empty");

        // R6: no readback strobe -> rd_data holds last value
        @(negedge clk);
        expect_at(SIG_RD, 50, 4, "R6 rd_data held");
        drain();

        // R5: serial load
        ser_load(20, 30);
        read_two(20, 30, "R5 serial load");

        // R9: partial reset keeps offsets, restarts alternation
        read_one(20, "R9 pre-reset readback");
        @(negedge clk);
        prst = 1'b1;
        repeat (2) @(negedge clk);
        prst = 1'b0;
        expect_at(SIG_AE, 0, 0, "R9 prst ae_n");
        expect_at(SIG_AF, 1, 0, "R9 prst af_n");
        drain();
        read_two(20, 30, "R9 offsets kept and order restarted");

        // R7: mode pin change without master reset has no effect
        @(negedge clk);
        flag_mode_sync = 1'b0;
        set_ptrs(50, 0, 0, 0);
        expect_at(SIG_AE, 0, 6, "R7 still synchronous");
        drain();
        ptr_check(0, 0, 0, 0, SIG_AE, 0, 2, "R7 restore");

        // R1 / R8: asynchronous mode, code 0 -> offset 7
        do_mrst(1'b0, 2'b00, 1'b0);
        drain();
        read_two(7, 7, "R1 default code0");

        @(negedge clk);
        set_ptrs(8, 0, 0, 0);
        expect_at(SIG_AE, 0, 3, "R8 ae release not yet");
        expect_at(SIG_AE, 1, 4, "R8 ae release from write side");
        drain();
        ptr_check(8, 0, 8, 1, SIG_AE, 0, 1, "R8 ae set on read move");

        @(negedge clk);
        set_ptrs(8, 0, 2042, 1);
        repeat (5) @(negedge clk);
        ptr_check(2042, 1, 2042, 1, SIG_AF, 0, 1, "R8 af set on write move");
        @(negedge clk);
        set_ptrs(2042, 1, 2042, 2);
        expect_at(SIG_AF, 0, 3, "R8 af release not yet");
        expect_at(SIG_AF, 1, 4, "R8 af release from read side");
        drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule